// File: doc/BRIEF.md
# Single-Operand Arithmetic and Normalize Unit

This unit applies one of five one-input operations to an operand of selectable size: zeroing, bitwise complement, two's-complement negation, magnitude (absolute value) and left-normalization. The operand size is byte, halfword, word or long. By default these are 8, 16, 32 and 64 bits. All of them derive from one base width parameter. The caller presents an operation code, a size code and the operand with a valid strobe. One clock later the unit presents the result, a sign flag, a zero flag, an overflow flag and, for normalization, a shift count.

Normalization shifts the operand toward its top bit until that bit at the selected width is 1. It reports how many positions it moved the operand. The count is always delivered at full counter width, whatever the operand size. The register file and the status-flag register are outside this unit. The surrounding datapath decides whether to commit the flags it reports.

Top module: `sop_unit`

## Requirements
- R1: After a synchronous reset, out_valid, out_result, out_count, out_ovf, out_neg and out_zero are all 0.
- R2: A request accepted with in_valid high produces out_valid high on the next rising edge, with its results. Any cycle with in_valid low drives out_valid low on the next edge and leaves all other outputs unchanged.
- R3: Size code 0/1/2/3 selects 8/16/32/64 bits (BYTE_W times 1/2/4/8). Operand bits above the selected width have no effect. Result bits above it are 0.
- R4: Operation code 0 (clear) and the unused codes 5, 6 and 7 give a zero result, zero count and no overflow.
- R5: Operation code 1 (invert) gives the bitwise complement of the operand at the selected width.
- R6: Operation code 2 (negate) gives the two's complement at the selected width. When the operand has only its top bit set, the result equals the operand and out_ovf is 1. Otherwise out_ovf is 0.
- R7: Operation code 3 (absolute value) negates a negative operand (top bit set) and passes a non-negative one unchanged. It raises out_ovf exactly in the only-top-bit-set case of R6.
- R8: Operation code 4 (normalize) of a nonzero operand returns the operand shifted left until its top bit at the selected width is 1. out_count is the number of positions shifted.
- R9: Normalize of a zero operand returns a zero result and sets out_zero. out_count equals the selected width in bits.
- R10: out_neg is the result's top bit at the selected width. out_zero is 1 exactly when the result is all zero. out_ovf is 0 except in the cases of R6 and R7.
- R11: out_count is a full CNT_W-bit value and is 0 for every operation other than normalize.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_op | input | 3 | Operation code (0 clear, 1 invert, 2 negate, 3 absolute, 4 normalize, 5-7 clear) |
| in_size | input | 2 | Size code (0 byte, 1 halfword, 2 word, 3 long) |
| in_opnd | input | DATA_W (64) | Operand, low bits used per size |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_result | output | DATA_W (64) | Result, zero-extended above the selected width |
| out_count | output | CNT_W (32) | Normalize shift count |
| out_ovf | output | 1 | Overflow flag |
| out_neg | output | 1 | Sign of result at selected width |
| out_zero | output | 1 | Result is zero |

## Verification
The assertions compare each output with the operation and size that were registered with it. They therefore assume that in_op and in_size are known, not X, whenever in_valid is high. The latency assertion does not judge the first cycle after reset. The bench always drives defined codes and never drops reset while a request is pending. It also fills operand bits above the selected width with pseudo-random values, so that the masking is checked under real traffic.

// File: rtl/sop_pkg.sv
package sop_pkg;
  typedef enum logic [2:0] {
    OP_CLR  = 3'd0,
    OP_INV  = 3'd1,
    OP_NEG  = 3'd2,
    OP_ABS  = 3'd3,
    OP_NORM = 3'd4
  } sop_op_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_LONG = 2'd3
  } sop_size_e;

  localparam int NUM_SIZES = 4;
endpackage

// File: rtl/sop_size_decode.sv
module sop_size_decode #(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 32,
  localparam int DATA_W = BYTE_W * 8
) (
  input  logic [1:0]        size,
  output logic [DATA_W-1:0] mask,
  output logic [DATA_W-1:0] sign,
  output logic [CNT_W-1:0]  width
);
  logic [DATA_W-1:0] mask_tab  [sop_pkg::NUM_SIZES];
  logic [DATA_W-1:0] sign_tab  [sop_pkg::NUM_SIZES];
  logic [CNT_W-1:0]  width_tab [sop_pkg::NUM_SIZES];

  for (genvar s = 0; s < sop_pkg::NUM_SIZES; s++) begin : g_size
    localparam int LW = BYTE_W << s;
    assign mask_tab[s]  = DATA_W'({LW{1'b1}});
    assign sign_tab[s]  = DATA_W'(1) << (LW - 1);
    assign width_tab[s] = CNT_W'(LW);
  end

  assign mask  = mask_tab[size];
  assign sign  = sign_tab[size];
  assign width = width_tab[size];
endmodule

// File: rtl/sop_arith.sv
module sop_arith #(
  parameter int DATA_W = 64
) (
  input  sop_pkg::sop_op_e  op,
  input  logic [DATA_W-1:0] opnd,
  input  logic [DATA_W-1:0] mask,
  input  logic [DATA_W-1:0] sign,
  output logic [DATA_W-1:0] result,
  output logic              ovf
);
  logic [DATA_W-1:0] negated;
  logic              is_negative;
  logic              is_min;

  assign negated     = (~opnd + DATA_W'(1)) & mask;
  assign is_negative = |(opnd & sign);
  assign is_min      = (opnd == sign);

  always_comb begin
    result = '0;
    ovf    = 1'b0;
    case (op)
      sop_pkg::OP_INV: result = ~opnd & mask;
      sop_pkg::OP_NEG: begin
        result = negated;
        ovf    = is_min;
      end
      sop_pkg::OP_ABS: begin
        result = is_negative ? negated : opnd;
        ovf    = is_min;
      end
      default: result = '0;
    endcase
  end
endmodule

// File: rtl/sop_norm.sv
module sop_norm #(
  parameter int DATA_W = 64,
  parameter int CNT_W  = 32
) (
  input  logic [DATA_W-1:0] opnd,
  input  logic [CNT_W-1:0]  width,
  output logic [DATA_W-1:0] shifted,
  output logic [CNT_W-1:0]  count
);
  logic [DATA_W-1:0] aligned;
  logic [CNT_W-1:0]  lead;

  assign aligned = opnd << (CNT_W'(DATA_W) - width);

  always_comb begin
    lead = CNT_W'(DATA_W);
    for (int i = 0; i < DATA_W; i++) begin
      if (aligned[i]) lead = CNT_W'(DATA_W - 1 - i);
    end
  end

  assign count   = (opnd == '0) ? width : lead;
  assign shifted = opnd << lead;
endmodule

// File: rtl/sop_unit.sv
module sop_unit #(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 32,
  localparam int DATA_W = BYTE_W * 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [2:0]        in_op,
  input  logic [1:0]        in_size,
  input  logic [DATA_W-1:0] in_opnd,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_result,
  output logic [CNT_W-1:0]  out_count,
  output logic              out_ovf,
  output logic              out_neg,
  output logic              out_zero
);
  import sop_pkg::*;

  logic [DATA_W-1:0] sz_mask, sz_sign, opnd_m;
  logic [CNT_W-1:0]  sz_width;
  logic [DATA_W-1:0] arith_res, norm_res, res_d;
  logic [CNT_W-1:0]  norm_cnt, cnt_d;
  logic              arith_ovf;
  sop_op_e           op_e;
  logic [2:0]        op_q;
  logic [1:0]        size_q;

  assign op_e = sop_op_e'(in_op);

  sop_size_decode #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_dec (
    .size(in_size), .mask(sz_mask), .sign(sz_sign), .width(sz_width)
  );

  assign opnd_m = in_opnd & sz_mask;

  sop_arith #(.DATA_W(DATA_W)) u_arith (
    .op(op_e), .opnd(opnd_m), .mask(sz_mask), .sign(sz_sign),
    .result(arith_res), .ovf(arith_ovf)
  );

  sop_norm #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_norm (
    .opnd(opnd_m), .width(sz_width), .shifted(norm_res), .count(norm_cnt)
  );

  assign res_d = (op_e == OP_NORM) ? norm_res : arith_res;
  assign cnt_d = (op_e == OP_NORM) ? norm_cnt : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_count  <= '0;
      out_ovf    <= 1'b0;
      out_neg    <= 1'b0;
      out_zero   <= 1'b0;
      op_q       <= '0;
      size_q     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result <= res_d;
        out_count  <= cnt_d;
        out_ovf    <= arith_ovf;
        out_neg    <= |(res_d & sz_sign);
        out_zero   <= (res_d == '0);
        op_q       <= in_op;
        size_q     <= in_size;
      end
    end
  end

  function automatic logic [DATA_W-1:0] mask_of(input logic [1:0] sz);
    return {DATA_W{1'b1}} >> (DATA_W - (BYTE_W << sz));
  endfunction

  function automatic logic [DATA_W-1:0] top_of(input logic [1:0] sz);
    return DATA_W'(1) << ((BYTE_W << sz) - 1);
  endfunction

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_valid == $past(in_valid))); // R2
  AST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((out_result & ~mask_of(size_q)) == '0)); // R3
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (out_valid && (op_q == 3'd0 || op_q > 3'd4)) |-> (out_result == '0 && !out_ovf)); // R4
  AST_OVF_MIN: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ovf) |-> (out_result == top_of(size_q))); // R6
  AST_NORM_LEAD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && op_q == 3'd4 && !out_zero) |-> |(out_result & top_of(size_q))); // R8
  AST_NORM_ZERO: assert property (@(posedge clk) disable iff (rst)
    (out_valid && op_q == 3'd4) |-> (out_zero == (out_count == CNT_W'(BYTE_W << size_q)))); // R9
  AST_COUNT_IDLE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && op_q != 3'd4) |-> (out_count == '0)); // R11
endmodule

// File: tb/sop_unit_tb.sv
module sop_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  in_op = '0;
  logic [1:0]  in_size = '0;
  logic [63:0] in_opnd = '0;
  logic        out_valid, out_ovf, out_neg, out_zero;
  logic [63:0] out_result;
  logic [31:0] out_count;
  int n_checks = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  sop_unit #(.BYTE_W(8), .CNT_W(32)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_size(in_size),
    .in_opnd(in_opnd), .out_valid(out_valid), .out_result(out_result),
    .out_count(out_count), .out_ovf(out_ovf), .out_neg(out_neg), .out_zero(out_zero)
  );

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  function automatic string op_tag(input int op, input logic [63:0] x);
    case (op)
      1: return "R5";
      2: return "R6";
      3: return "R7";
      4: return (x == 0) ? "R9" : "R8";
      default: return "R4";
    endcase
  endfunction

  task automatic run_op(input int op, input int sz, input logic [63:0] val);
    int w;
    logic [63:0] m, mn, x, r, garbage;
    logic [31:0] c;
    logic ov;
    w  = 8 << sz;
    m  = (w == 64) ? '1 : ((64'd1 << w) - 1);
    mn = 64'd1 << (w - 1);
    x  = val & m;
    r  = 0; c = 0; ov = 0;
    case (op)
      1: r = ~x & m;
      2: begin r = (64'd0 - x) & m; ov = (x == mn); end
      3: begin r = ((x & mn) != 0) ? ((64'd0 - x) & m) : x; ov = (x == mn); end
      4: begin
        if (x == 0) c = w;
        else begin
          r = x;
          while ((r & mn) == 0) begin r = r << 1; c++; end
        end
      end
      default: r = 0;
    endcase
    garbage = {$urandom, $urandom};
    @(negedge clk);
    in_valid = 1'b1;
    in_op    = 3'(op);
    in_size  = 2'(sz);
    in_opnd  = (garbage & ~m) | x;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 valid", 128'(out_valid), 128'(1));
    check(op_tag(op, x), 128'(out_result & m), 128'(r));
    check("R3 upper", 128'(out_result & ~m), 128'(0));
    check("R10 flags", 128'({out_ovf, out_neg, out_zero}),
          128'({ov, (r & mn) != 0, r == 0}));
    check((op == 4) ? op_tag(op, x) : "R11", 128'(out_count), 128'(c));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [63:0] held;
    in_opnd = '1; in_op = 3'd1; in_valid = 1'b1;
    repeat (3) @(negedge clk);
    // R1: outputs cleared while reset is held
    check("R1 reset", 128'({out_valid, out_ovf, out_neg, out_zero, out_count, out_result}), 128'(0));
    in_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // byte: exhaustive, all eight codes
    for (int op = 0; op < 8; op++)
      for (int v = 0; v < 256; v++) run_op(op, 0, 64'(v));

    // halfword: strided sweep plus corners
    for (int op = 0; op < 8; op++) begin
      for (int i = 0; i < 262; i++) run_op(op, 1, 64'(i * 251));
      run_op(op, 1, 64'h8000);
      run_op(op, 1, 64'hFFFF);
    end

    // word and long: walking bits, corners and random values
    for (int sz = 2; sz < 4; sz++)
      for (int op = 0; op < 8; op++) begin
        for (int b = 0; b < (8 << sz); b++) begin
          run_op(op, sz, 64'd1 << b);
          run_op(op, sz, (64'd1 << b) - 1);
        end
        run_op(op, sz, 64'd0);
        run_op(op, sz, '1);
        for (int k = 0; k < 16; k++) run_op(op, sz, {$urandom, $urandom});
      end

    // R2: idle cycles hold results and drop out_valid
    run_op(2, 1, 64'h1234);
    held = out_result;
    in_op = 3'd1; in_opnd = 64'hDEAD_BEEF; in_size = 2'd3;
    repeat (3) @(negedge clk);
    check("R2 idle valid", 128'(out_valid), 128'(0));
    check("R2 hold", 128'(out_result), 128'(held));

    finish_run();
  end
endmodule